// File: doc/BRIEF.md
# Pointer Justification Event Counter

This block tallies positive and negative pointer justification events for a single tributary channel. Two single-cycle strobes report an upward and a downward justification. Each direction has its own running tally. A monitoring-interval strobe copies each tally into a readable snapshot register and restarts the tally. A mode input chooses what a full tally does on the next event: it either sticks at its top value or wraps back to zero. A force-zero input is raised while the channel is in alarm (pointer lost or alarm indication requested). While it is high, every tally and every snapshot reads zero.

A small control state machine turns the strobes into one command per cycle. Its states are ST_RUN (normal counting) and ST_FRC (counts forced to zero). Transition T_ENTER goes from ST_RUN to ST_FRC when force_zero is sampled high. Transition T_LEAVE goes from ST_FRC back to ST_RUN when force_zero is sampled low. Each state loops on itself otherwise. The commands are CMD_CLEAR, CMD_SNAP and CMD_RUN. Force-zero has priority over the interval strobe, and the interval strobe has priority over plain counting. All state changes take effect at the rising clock edge that samples the inputs. The snapshot outputs show the new value one edge after the strobe.

Top module: `jc_event_counter`

## Requirements
- R1: Separate 4-bit tallies are kept for up events (up_evt) and down events (down_evt). Each sampled strobe adds one to its own tally only.
- R2: At an edge that samples pm_tick high with force_zero low, each snapshot output takes the value of its tally, and each tally restarts.
- R3: With sat_mode = 1, a tally at 15 stays at 15 on further events.
- R4: With sat_mode = 0, a tally at 15 wraps to 0 on the next event.
- R5: At every edge that samples force_zero high, both tallies and both snapshots become 0, and events and pm_tick in that cycle are ignored.
- R6: An event sampled together with pm_tick counts in the new interval: the tally becomes 1, and the snapshot receives the old total without that event.
- R7: The snapshot outputs change only at a pm_tick edge, a force_zero edge or a reset edge. Events alone leave them unchanged.
- R8: Up and down strobes sampled in the same cycle each update their own tally independently.
- R9: At an edge that samples rst_n low (synchronous, active low), all four registers become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_evt | input | 1 | Positive justification strobe |
| down_evt | input | 1 | Negative justification strobe |
| pm_tick | input | 1 | Monitoring interval strobe |
| sat_mode | input | 1 | 1 = saturate at maximum, 0 = wrap |
| force_zero | input | 1 | Alarm-driven clear of all counts |
| up_snap | output | 4 | Snapshot of the up tally |
| down_snap | output | 4 | Snapshot of the down tally |

## Verification
The tallies are not visible at the ports. A wrong tally therefore shows up only at the next interval strobe, one edge after it is sampled, as a wrong snapshot value. A control state stuck in ST_FRC, or a wrong command priority, shows up in the first snapshot after the alarm clears. A snapshot register that loads at the wrong time shows up at once, within one edge of any plain event, as a change at the outputs.

// File: rtl/jc_pkg.sv
package jc_pkg;
    typedef enum logic {
        ST_RUN = 1'b0,
        ST_FRC = 1'b1
    } ctrl_state_e;

    typedef enum logic [1:0] {
        CMD_RUN   = 2'd0,
        CMD_SNAP  = 2'd1,
        CMD_CLEAR = 2'd2
    } cnt_cmd_e;

    localparam int unsigned NUM_DIR = 2;
endpackage

// File: rtl/jc_ctrl.sv
module jc_ctrl
    import jc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pm_tick,
    input  logic     force_zero,
    output cnt_cmd_e cmd,
    output logic     zero_known
);
    ctrl_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Next state: T_ENTER / T_LEAVE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: if (force_zero)  state_d = ST_FRC;
            ST_FRC: if (!force_zero) state_d = ST_RUN;
        endcase
    end

    // Output decode: clear beats snapshot beats count
    always_comb begin
        cmd        = CMD_RUN;
        zero_known = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (force_zero)   cmd = CMD_CLEAR;
                else if (pm_tick) cmd = CMD_SNAP;
            end
            ST_FRC: begin
                zero_known = 1'b1;
                if (force_zero)   cmd = CMD_CLEAR;
                else if (pm_tick) cmd = CMD_SNAP;
            end
        endcase
    end
endmodule

// File: rtl/jc_run_cnt.sv
module jc_run_cnt
    import jc_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_cmd_e         cmd,
    input  logic             evt,
    input  logic             sat_mode,
    output logic [CNT_W-1:0] run
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] TOP  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] run_d;
    logic [CNT_W-1:0] bumped;

    always_comb begin
        if (sat_mode && run == TOP) bumped = run;
        else                        bumped = run + ONE;
    end

    always_comb begin
        run_d = run;
        unique case (cmd)
            CMD_CLEAR: run_d = ZERO;
            CMD_SNAP:  run_d = evt ? ONE : ZERO;
            CMD_RUN:   run_d = evt ? bumped : run;
            default:   run_d = ZERO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) run <= ZERO;
        else        run <= run_d;
    end
endmodule

// File: rtl/jc_hold_reg.sv
module jc_hold_reg
    import jc_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_cmd_e         cmd,
    input  logic             zero_known,
    input  logic [CNT_W-1:0] run_in,
    output logic [CNT_W-1:0] hold
);
    logic [CNT_W-1:0] hold_d;

    always_comb begin
        hold_d = hold;
        unique case (cmd)
            CMD_CLEAR: hold_d = '0;
            CMD_SNAP:  hold_d = zero_known ? '0 : run_in;
            CMD_RUN:   hold_d = hold;
            default:   hold_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold <= '0;
        else        hold <= hold_d;
    end
endmodule

// File: rtl/jc_event_counter.sv
module jc_event_counter
    import jc_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_evt,
    input  logic             down_evt,
    input  logic             pm_tick,
    input  logic             sat_mode,
    input  logic             force_zero,
    output logic [CNT_W-1:0] up_snap,
    output logic [CNT_W-1:0] down_snap
);
    cnt_cmd_e         cmd;
    logic             zero_known;
    logic [NUM_DIR-1:0] evt_vec;
    logic [CNT_W-1:0] run_vec  [NUM_DIR];
    logic [CNT_W-1:0] hold_vec [NUM_DIR];
    logic [CNT_W-1:0] run_up;
    logic [CNT_W-1:0] run_down;

    assign evt_vec = {down_evt, up_evt};

    jc_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pm_tick    (pm_tick),
        .force_zero (force_zero),
        .cmd        (cmd),
        .zero_known (zero_known)
    );

    for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
        jc_run_cnt #(.CNT_W(CNT_W)) u_run (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd      (cmd),
            .evt      (evt_vec[g]),
            .sat_mode (sat_mode),
            .run      (run_vec[g])
        );
        jc_hold_reg #(.CNT_W(CNT_W)) u_hold (
            .clk        (clk),
            .rst_n      (rst_n),
            .cmd        (cmd),
            .zero_known (zero_known),
            .run_in     (run_vec[g]),
            .hold       (hold_vec[g])
        );
    end

    assign run_up    = run_vec[0];
    assign run_down  = run_vec[1];
    assign up_snap   = hold_vec[0];
    assign down_snap = hold_vec[1];
endmodule

// File: rtl/jc_event_counter_chk.sv
module jc_event_counter_chk #(
    parameter int unsigned CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             up_evt,
    input logic             down_evt,
    input logic             pm_tick,
    input logic             sat_mode,
    input logic             force_zero,
    input logic [CNT_W-1:0] run_up,
    input logic [CNT_W-1:0] run_down,
    input logic [CNT_W-1:0] up_snap,
    input logic [CNT_W-1:0] down_snap
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    p_force_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        force_zero |=> (up_snap == '0 && down_snap == '0 && run_up == '0 && run_down == '0));

    p_snap_takes_tally_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_tick && !force_zero) |=> (up_snap == $past(run_up) && down_snap == $past(run_down)));

    p_new_interval_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_tick && !force_zero && up_evt) |=> (run_up == CNT_W'(1)));

    p_snap_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pm_tick && !force_zero) |=> ($stable(up_snap) && $stable(down_snap)));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_mode && run_up == TOP && up_evt && !pm_tick && !force_zero) |=> (run_up == TOP));

    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sat_mode && run_down == TOP && down_evt && !pm_tick && !force_zero) |=> (run_down == '0));

    p_idle_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_evt && !pm_tick && !force_zero) |=> $stable(run_up));
endmodule

bind jc_event_counter jc_event_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_evt     (up_evt),
    .down_evt   (down_evt),
    .pm_tick    (pm_tick),
    .sat_mode   (sat_mode),
    .force_zero (force_zero),
    .run_up     (run_up),
    .run_down   (run_down),
    .up_snap    (up_snap),
    .down_snap  (down_snap)
);

// File: tb/jc_event_counter_tb.sv
module jc_event_counter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         up_evt = 1'b0;
    logic         down_evt = 1'b0;
    logic         pm_tick = 1'b0;
    logic         sat_mode = 1'b0;
    logic         force_zero = 1'b0;
    logic [W-1:0] up_snap;
    logic [W-1:0] down_snap;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    jc_event_counter #(.CNT_W(W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .up_evt     (up_evt),
        .down_evt   (down_evt),
        .pm_tick    (pm_tick),
        .sat_mode   (sat_mode),
        .force_zero (force_zero),
        .up_snap    (up_snap),
        .down_snap  (down_snap)
    );

    // Called at a falling edge; drives one cycle, returns at the next falling edge
    task automatic step(input logic u, input logic d, input logic t, input logic f);
        up_evt = u; down_evt = d; pm_tick = t; force_zero = f;
        @(posedge clk);
        @(negedge clk);
        up_evt = 1'b0; down_evt = 1'b0; pm_tick = 1'b0; force_zero = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0);
    endtask

    task automatic check(input string req, input logic [W-1:0] exp_u, input logic [W-1:0] exp_d);
        total++;
        if (up_snap !== exp_u || down_snap !== exp_d) begin
            bad++;
            $display("FAIL %s: up_snap=%0d down_snap=%0d expected %0d %0d",
                     req, up_snap, down_snap, exp_u, exp_d);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        step(1, 1, 1, 0);
        step(1, 1, 0, 0);
        rst_n = 1'b1;
        check("R9 reset", 0, 0);
        step(0, 0, 1, 0);
        check("R9 tallies clear after reset", 0, 0);
    endtask

    task automatic t_basic;
        sat_mode = 1'b1;
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0);
        for (int i = 0; i < 3; i++) step(0, 1, 0, 0);
        step(0, 0, 1, 0);
        check("R1 R2 snapshot", 5, 3);
        step(0, 0, 1, 0);
        check("R2 tally restarted", 0, 0);
    endtask

    task automatic t_saturate;
        sat_mode = 1'b1;
        for (int i = 0; i < 20; i++) step(1, 1, 0, 0);
        step(0, 0, 1, 0);
        check("R3 saturate", 15, 15);
    endtask

    task automatic t_wrap;
        sat_mode = 1'b0;
        for (int i = 0; i < 17; i++) step(1, 0, 0, 0);
        for (int i = 0; i < 16; i++) step(0, 1, 0, 0);
        step(0, 0, 1, 0);
        check("R4 wrap", 1, 0);
        sat_mode = 1'b1;
    endtask

    task automatic t_coincide;
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0);
        step(1, 1, 1, 0);
        check("R6 old total to snapshot", 3, 0);
        step(0, 0, 1, 0);
        check("R6 event in new interval", 1, 1);
    endtask

    task automatic t_both;
        for (int i = 0; i < 4; i++) step(1, 1, 0, 0);
        step(1, 0, 0, 0);
        step(0, 0, 1, 0);
        check("R8 simultaneous strobes", 5, 4);
    endtask

    task automatic t_stable;
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0);
        step(0, 1, 1, 0);
        check("R7 snapshot loaded", 5, 0);
        for (int i = 0; i < 6; i++) begin
            step(1, 1, 0, 0);
            check("R7 snapshot unchanged by events", 5, 0);
        end
        step(0, 0, 1, 0);
        check("R7 tally kept counting", 6, 7);
    endtask

    task automatic t_force;
        for (int i = 0; i < 6; i++) step(1, 0, 0, 0);
        step(0, 0, 1, 0);
        check("R5 pre-force snapshot", 6, 0);
        step(1, 1, 0, 0);
        step(1, 1, 0, 0);
        step(1, 1, 0, 1);
        check("R5 force clears snapshot", 0, 0);
        step(1, 1, 1, 1);
        check("R5 tick ignored under force", 0, 0);
        step(0, 0, 1, 0);
        check("R5 tallies cleared", 0, 0);
        step(1, 0, 0, 1);
        step(0, 1, 0, 0);
        step(0, 0, 1, 0);
        check("R5 counting resumes after force", 0, 1);
    endtask

    task automatic t_midreset;
        for (int i = 0; i < 4; i++) step(1, 1, 0, 0);
        step(0, 0, 1, 0);
        check("R9 pre-reset snapshot", 4, 4);
        step(1, 1, 0, 0);
        rst_n = 1'b0;
        step(0, 0, 0, 0);
        rst_n = 1'b1;
        check("R9 mid-run reset", 0, 0);
        step(0, 0, 1, 0);
        check("R9 tallies zero after reset", 0, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_saturate();
        t_wrap();
        t_coincide();
        t_both();
        t_stable();
        t_force();
        t_midreset();
        idle(2);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
        end
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
        end
        $finish;
    end
endmodule